// File: doc/BRIEF.md
# Asynchronous DRAM Strobe Cycle Decoder

This block sits on the device side of an asynchronous DRAM interface. It samples the four active-low control strobes (row strobe, column strobe, write enable and output enable) and the multiplexed address bus on a fast system clock. From the order in which the strobe edges arrive it works out what kind of access each row-strobe cycle is. It then drives one-cycle pulses and levels to the storage core: latch a row, latch a column, capture write data, drive read data, and refresh a row.

The row-strobe falling edge opens a cycle. If the column strobe is already low at that moment, the cycle is an internal-counter refresh. Otherwise the address is latched as a row. Each column-strobe fall inside an open row latches a new column on that row, which gives page mode. Write data is captured on whichever of write-enable and column-strobe falls later. An 11-bit internal row counter supplies refresh rows. A second column-strobe fall inside a counter refresh starts a counter test access on the counter's row.

A 3-bit cycle code is published when the row strobe rises. Strobes cross into the clock domain through two-flop synchronizers. When two strobes change in the same sample, the column strobe counts as having moved first.

Top module: `dram_strobe_decoder`

## Requirements
- R1: While reset is high and after it is released, row_latch, col_latch, din_latch, refresh and dout_en are 0, cycle_kind is 0 and the refresh row counter is 0.
- R2: A row-strobe fall with the column strobe high gives exactly one row_latch pulse, with row_addr equal to the address. The pulse is high in the third clock cycle after the input change.
- R3: Every column-strobe fall while the row strobe is low in an addressed cycle gives one col_latch pulse, with col_addr equal to the low 10 address bits. Several falls in one row-strobe period each latch a new column on the same row.
- R4: din_latch pulses once per column access, at the later of the write-enable fall and the column-strobe fall. If both fall in the same sample, the access counts as a late write.
- R5: dout_en is high only after a read column latch, and only while the column strobe is low, output enable is low and write enable is high. It drops when the column strobe or output enable rises.
- R6: dout_en stays low for a whole early write, meaning write enable was low before the column strobe fell, even when output enable is low.
- R7: A row-strobe period with no column-strobe fall gives one refresh pulse at the row-strobe rise. refresh_row equals the latched row, and dout_en stays low.
- R8: A row-strobe fall with the column strobe low, including a fall in the same sample, gives a refresh pulse with refresh_row equal to the counter and no row_latch. The counter then advances by one and wraps from 2047 to 0.
- R9: If the column strobe is kept low after a read and the row strobe is cycled, a counter refresh follows and dout_en stays high throughout.
- R10: A column-strobe rise and fall inside a counter refresh latches a column and enables read and write. row_addr holds the counter value used by that refresh.
- R11: cycle_kind updates at each row-strobe rise. The codes are: 1 read, 2 early write, 3 late write (delayed or read-modify-write), 4 row-only refresh, 5 counter refresh, 6 hidden refresh, 7 counter test. In page mode the code reflects the last access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | sampling clock |
| rst | input | 1 | synchronous active-high reset |
| ras_n | input | 1 | row strobe, active low |
| cas_n | input | 1 | column strobe, active low |
| we_n | input | 1 | write enable, active low |
| oe_n | input | 1 | output enable, active low |
| addr | input | 11 | multiplexed row/column address |
| row_latch | output | 1 | one-cycle pulse: row captured |
| row_addr | output | 11 | row of the current cycle |
| col_latch | output | 1 | one-cycle pulse: column captured |
| col_addr | output | 10 | latched column |
| din_latch | output | 1 | one-cycle pulse: capture write data |
| dout_en | output | 1 | drive read data |
| refresh | output | 1 | one-cycle pulse: refresh a row |
| refresh_row | output | 11 | row to refresh |
| cycle_kind | output | 3 | code of the last completed cycle |

## Verification
Every result lands three clock edges after the input change that causes it: two synchronizer stages, then one output register. Strobes and address are driven on the falling clock edge. The row-latch pulse is checked to be low after two cycles and high after the third. All other pulses are counted on falling edges, and their counts and captured values are compared once four cycles have passed after each stimulus, so the exact edge does not matter. Levels such as dout_en and cycle_kind are read after that same four-cycle wait.

// File: rtl/dsd_pkg.sv
package dsd_pkg;

    typedef enum logic [2:0] {
        CK_NONE     = 3'd0,
        CK_READ     = 3'd1,
        CK_EARLY_WR = 3'd2,
        CK_LATE_WR  = 3'd3,
        CK_RAS_ONLY = 3'd4,
        CK_CBR      = 3'd5,
        CK_HIDDEN   = 3'd6,
        CK_CTEST    = 3'd7
    } cyc_kind_e;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_ROW,
        PH_REFR,
        PH_CTEST
    } phase_e;

    // strobe levels, 1 = asserted (pin low)
    typedef struct packed {
        logic ras;
        logic cas;
        logic we;
        logic oe;
    } strobe_t;

    typedef struct packed {
        logic ras_fall;
        logic ras_rise;
        logic cas_fall;
        logic cas_rise;
        logic we_fall;
    } edges_t;

    // "fall" means the strobe became asserted
    function automatic edges_t find_edges(strobe_t now, strobe_t prev);
        edges_t e;
        e.ras_fall = now.ras & ~prev.ras;
        e.ras_rise = ~now.ras & prev.ras;
        e.cas_fall = now.cas & ~prev.cas;
        e.cas_rise = ~now.cas & prev.cas;
        e.we_fall  = now.we & ~prev.we;
        return e;
    endfunction

endpackage

// File: rtl/dsd_strobe_sync.sv
module dsd_strobe_sync
    import dsd_pkg::*;
#(
    parameter int AW     = 11,
    parameter int STAGES = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [3:0]    strobe_n,
    input  logic [AW-1:0] addr,
    output strobe_t       cur,
    output strobe_t       prv,
    output logic [AW-1:0] addr_al
);
    localparam int NSTR = 4;

    logic [STAGES:0][NSTR-1:0] spipe;
    logic [STAGES-1:0][AW-1:0] apipe;

    always_ff @(posedge clk) begin
        if (rst) begin
            spipe <= '1;
            apipe <= '0;
        end else begin
            spipe[0] <= strobe_n;
            apipe[0] <= addr;
            for (int i = 1; i <= STAGES; i++) spipe[i] <= spipe[i-1];
            for (int i = 1; i < STAGES; i++)  apipe[i] <= apipe[i-1];
        end
    end

    logic [NSTR-1:0] cur_bits, prv_bits;
    generate
        for (genvar b = 0; b < NSTR; b++) begin : g_pol
            assign cur_bits[b] = ~spipe[STAGES-1][b];
            assign prv_bits[b] = ~spipe[STAGES][b];
        end
    endgenerate

    assign cur     = strobe_t'(cur_bits);
    assign prv     = strobe_t'(prv_bits);
    assign addr_al = apipe[STAGES-1];

endmodule

// File: rtl/dsd_refresh_ctr.sv
module dsd_refresh_ctr #(
    parameter int W = 11
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         step,
    output logic [W-1:0] cnt
);
    always_ff @(posedge clk) begin
        if (rst)       cnt <= '0;
        else if (step) cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/dsd_cycle_fsm.sv
module dsd_cycle_fsm
    import dsd_pkg::*;
#(
    parameter int ROW_W = 11,
    parameter int COL_W = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  strobe_t          cur,
    input  strobe_t          prv,
    input  logic [ROW_W-1:0] addr_al,
    input  logic [ROW_W-1:0] ref_cnt,
    output logic             ctr_step,
    output logic             row_latch,
    output logic [ROW_W-1:0] row_addr,
    output logic             col_latch,
    output logic [COL_W-1:0] col_addr,
    output logic             din_latch,
    output logic             dout_en,
    output logic             refresh,
    output logic [ROW_W-1:0] refresh_row,
    output cyc_kind_e        cycle_kind
);
    phase_e    phase;
    cyc_kind_e kind_cur, kind_nx;
    logic      col_open, open_nx;
    logic      early, early_nx;
    logic      col_go, din_go, dout_nx, col_ph;
    edges_t    e;

    assign e        = find_edges(cur, prv);
    assign ctr_step = e.ras_fall & cur.cas;
    assign col_ph   = (phase == PH_ROW) || (phase == PH_CTEST) || (phase == PH_REFR);

    always_comb begin
        kind_nx  = kind_cur;
        open_nx  = col_open;
        early_nx = early;
        col_go   = 1'b0;
        din_go   = 1'b0;
        if (e.ras_fall) begin
            if (cur.cas) kind_nx = col_open ? CK_HIDDEN : CK_CBR;
            else         kind_nx = CK_RAS_ONLY;
        end else if (e.cas_fall && col_ph) begin
            col_go   = 1'b1;
            open_nx  = 1'b1;
            early_nx = cur.we & prv.we;
            din_go   = cur.we;
            if (phase != PH_ROW)   kind_nx = CK_CTEST;
            else if (early_nx)     kind_nx = CK_EARLY_WR;
            else if (cur.we)       kind_nx = CK_LATE_WR;
            else                   kind_nx = CK_READ;
        end else if (e.we_fall && cur.cas && col_open &&
                     (phase == PH_ROW || phase == PH_CTEST)) begin
            din_go = 1'b1;
            if (phase == PH_ROW) kind_nx = CK_LATE_WR;
        end
        if (e.cas_rise) begin
            open_nx  = 1'b0;
            early_nx = 1'b0;
        end
        dout_nx = open_nx & ~early_nx & cur.cas & cur.oe & ~cur.we;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase       <= PH_IDLE;
            kind_cur    <= CK_NONE;
            cycle_kind  <= CK_NONE;
            col_open    <= 1'b0;
            early       <= 1'b0;
            row_latch   <= 1'b0;
            col_latch   <= 1'b0;
            din_latch   <= 1'b0;
            refresh     <= 1'b0;
            dout_en     <= 1'b0;
            row_addr    <= '0;
            col_addr    <= '0;
            refresh_row <= '0;
        end else begin
            row_latch <= 1'b0;
            refresh   <= 1'b0;
            col_latch <= col_go;
            din_latch <= din_go;
            dout_en   <= dout_nx;
            col_open  <= open_nx;
            early     <= early_nx;
            kind_cur  <= kind_nx;
            if (col_go) begin
                col_addr <= addr_al[COL_W-1:0];
                if (phase == PH_REFR) phase <= PH_CTEST;
            end
            if (e.ras_fall) begin
                if (cur.cas) begin
                    phase       <= PH_REFR;
                    refresh     <= 1'b1;
                    refresh_row <= ref_cnt;
                    row_addr    <= ref_cnt;
                end else begin
                    phase     <= PH_ROW;
                    row_latch <= 1'b1;
                    row_addr  <= addr_al;
                end
            end else if (e.ras_rise) begin
                phase      <= PH_IDLE;
                cycle_kind <= kind_nx;
                if (phase == PH_ROW && kind_nx == CK_RAS_ONLY) begin
                    refresh     <= 1'b1;
                    refresh_row <= row_addr;
                end
            end
        end
    end

    assert_row_pulse_R2: assert property (@(posedge clk) disable iff (rst)
        row_latch |=> !row_latch);

    assert_col_pulse_R3: assert property (@(posedge clk) disable iff (rst)
        col_latch |=> !col_latch);

    // R8: a refresh never coincides with a row capture
    assert_refresh_excl_R8: assert property (@(posedge clk) disable iff (rst)
        refresh |-> !row_latch);

endmodule

// File: rtl/dram_strobe_decoder.sv
module dram_strobe_decoder
    import dsd_pkg::*;
#(
    parameter int ROW_W  = 11,
    parameter int COL_W  = 10,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ras_n,
    input  logic             cas_n,
    input  logic             we_n,
    input  logic             oe_n,
    input  logic [ROW_W-1:0] addr,
    output logic             row_latch,
    output logic [ROW_W-1:0] row_addr,
    output logic             col_latch,
    output logic [COL_W-1:0] col_addr,
    output logic             din_latch,
    output logic             dout_en,
    output logic             refresh,
    output logic [ROW_W-1:0] refresh_row,
    output logic [2:0]       cycle_kind
);
    localparam int LAT = STAGES + 1;

    strobe_t          cur, prv;
    logic [ROW_W-1:0] addr_al, ref_cnt;
    logic             ctr_step;
    cyc_kind_e        kind;

    dsd_strobe_sync #(.AW(ROW_W), .STAGES(STAGES)) u_sync (
        .clk(clk), .rst(rst),
        .strobe_n({ras_n, cas_n, we_n, oe_n}),
        .addr(addr),
        .cur(cur), .prv(prv), .addr_al(addr_al)
    );

    dsd_refresh_ctr #(.W(ROW_W)) u_ctr (
        .clk(clk), .rst(rst), .step(ctr_step), .cnt(ref_cnt)
    );

    dsd_cycle_fsm #(.ROW_W(ROW_W), .COL_W(COL_W)) u_fsm (
        .clk(clk), .rst(rst),
        .cur(cur), .prv(prv), .addr_al(addr_al), .ref_cnt(ref_cnt),
        .ctr_step(ctr_step),
        .row_latch(row_latch), .row_addr(row_addr),
        .col_latch(col_latch), .col_addr(col_addr),
        .din_latch(din_latch), .dout_en(dout_en),
        .refresh(refresh), .refresh_row(refresh_row),
        .cycle_kind(kind)
    );

    assign cycle_kind = kind;

    // R5: read data only while the pins showed CAS low, OE low, WE high
    assert_dout_gate_R5: assert property (@(posedge clk) disable iff (rst)
        dout_en |-> ($past(cas_n, LAT) == 1'b0 && $past(oe_n, LAT) == 1'b0
                     && $past(we_n, LAT) == 1'b1));

    // R4: data capture only with CAS and WE both low at the pins
    assert_din_gate_R4: assert property (@(posedge clk) disable iff (rst)
        din_latch |-> ($past(cas_n, LAT) == 1'b0 && $past(we_n, LAT) == 1'b0));

endmodule

// File: tb/dram_strobe_decoder_test.sv
module dram_strobe_decoder_test;
    logic        clk = 1'b0;
    logic        rst;
    logic        ras_n, cas_n, we_n, oe_n;
    logic [10:0] addr;
    logic        row_latch, col_latch, din_latch, dout_en, refresh;
    logic [10:0] row_addr, refresh_row;
    logic [9:0]  col_addr;
    logic [2:0]  cycle_kind;

    always #4 clk = ~clk;

    dram_strobe_decoder uut (
        .clk(clk), .rst(rst), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
        .oe_n(oe_n), .addr(addr), .row_latch(row_latch), .row_addr(row_addr),
        .col_latch(col_latch), .col_addr(col_addr), .din_latch(din_latch),
        .dout_en(dout_en), .refresh(refresh), .refresh_row(refresh_row),
        .cycle_kind(cycle_kind)
    );

    int n_run = 0, n_fail = 0;
    int c_row = 0, c_col = 0, c_din = 0, c_ref = 0;
    logic [10:0] last_rr = '0;
    logic [10:0] exp_ctr = '0;

    always @(negedge clk) begin
        if (row_latch) c_row++;
        if (col_latch) c_col++;
        if (din_latch) c_din++;
        if (refresh) begin c_ref++; last_rr = refresh_row; end
    end

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    task automatic idle_pins();
        ras_n = 1; cas_n = 1; we_n = 1; oe_n = 1;
        settle();
    endtask

    task automatic t_reset();
        rst = 1; ras_n = 1; cas_n = 1; we_n = 1; oe_n = 1; addr = '0;
        repeat (3) @(negedge clk);
        rst = 0;
        settle();
        chk("R1 pulses", {row_latch, col_latch, din_latch, refresh}, 0);
        chk("R1 dout_en", dout_en, 0);
        chk("R1 cycle_kind", cycle_kind, 0);
    endtask

    task automatic t_read(logic [10:0] r, logic [9:0] c);
        int b_row = c_row, b_col = c_col;
        addr = r; ras_n = 0;
        repeat (2) @(negedge clk);
        chk("R2 row pulse not before third cycle", row_latch, 0);
        @(negedge clk);
        chk("R2 row pulse in third cycle", row_latch, 1);
        chk("R2 row_addr", row_addr, r);
        @(negedge clk);
        addr = {1'b0, c}; oe_n = 0; cas_n = 0;
        settle();
        chk("R3 col count", c_col - b_col, 1);
        chk("R3 col_addr", col_addr, c);
        chk("R5 dout on read", dout_en, 1);
        oe_n = 1; settle();
        chk("R5 dout off with OE high", dout_en, 0);
        oe_n = 0; settle();
        chk("R5 dout back with OE low", dout_en, 1);
        cas_n = 1; settle();
        chk("R5 dout off with CAS high", dout_en, 0);
        ras_n = 1; settle();
        chk("R11 kind read", cycle_kind, 1);
        chk("R2 single row pulse", c_row - b_row, 1);
        idle_pins();
    endtask

    task automatic t_early();
        int b_din = c_din;
        addr = 11'h123; ras_n = 0; settle();
        we_n = 0; oe_n = 0; settle();
        addr = 11'h0AA; cas_n = 0; settle();
        chk("R4 din at CAS fall", c_din - b_din, 1);
        chk("R6 no dout in early write", dout_en, 0);
        we_n = 1; settle();
        chk("R6 no dout after WE high", dout_en, 0);
        cas_n = 1; ras_n = 1; settle();
        chk("R11 kind early", cycle_kind, 2);
        idle_pins();
    endtask

    task automatic t_delayed();
        int b_din = c_din;
        addr = 11'h321; ras_n = 0; settle();
        addr = 11'h055; cas_n = 0; settle();
        chk("R4 no din before WE", c_din - b_din, 0);
        we_n = 0; settle();
        chk("R4 din at WE fall", c_din - b_din, 1);
        cas_n = 1; we_n = 1; ras_n = 1; settle();
        chk("R11 kind late", cycle_kind, 3);
        idle_pins();
    endtask

    task automatic t_we_cas_same();
        int b_din = c_din;
        addr = 11'h00F; ras_n = 0; settle();
        cas_n = 0; we_n = 0; settle();
        chk("R4 din once on joint fall", c_din - b_din, 1);
        cas_n = 1; we_n = 1; ras_n = 1; settle();
        chk("R4 joint fall is late write", cycle_kind, 3);
        idle_pins();
    endtask

    task automatic t_ras_only(logic [10:0] r);
        int b_ref = c_ref;
        addr = r; ras_n = 0; oe_n = 0; settle();
        chk("R7 no refresh before rise", c_ref - b_ref, 0);
        ras_n = 1; settle();
        chk("R7 refresh count", c_ref - b_ref, 1);
        chk("R7 refresh_row", last_rr, r);
        chk("R7 dout low", dout_en, 0);
        chk("R11 kind ras-only", cycle_kind, 4);
        idle_pins();
    endtask

    task automatic t_cbr(logic same);
        int b_ref = c_ref, b_row = c_row;
        addr = 11'h7AB;
        cas_n = 0;
        if (!same) settle();
        ras_n = 0; settle();
        chk("R8 refresh count", c_ref - b_ref, 1);
        chk("R8 counter row", last_rr, exp_ctr);
        chk("R8 no row latch", c_row - b_row, 0);
        exp_ctr++;
        ras_n = 1; settle();
        chk("R11 kind cbr", cycle_kind, 5);
        idle_pins();
    endtask

    task automatic t_hidden();
        int b_ref = c_ref;
        addr = 11'h2F0; ras_n = 0; settle();
        addr = 11'h011; oe_n = 0; cas_n = 0; settle();
        ras_n = 1; settle();
        chk("R9 dout held across RAS high", dout_en, 1);
        ras_n = 0; settle();
        chk("R9 hidden refresh count", c_ref - b_ref, 1);
        chk("R9 hidden refresh row", last_rr, exp_ctr);
        chk("R9 dout held in refresh", dout_en, 1);
        exp_ctr++;
        ras_n = 1; settle();
        chk("R11 kind hidden", cycle_kind, 6);
        chk("R9 dout still held", dout_en, 1);
        idle_pins();
    endtask

    task automatic t_ctest();
        int b_col = c_col, b_din = c_din;
        logic [10:0] used = exp_ctr;
        cas_n = 0; settle();
        ras_n = 0; settle();
        exp_ctr++;
        cas_n = 1; settle();
        addr = 11'h1C3; cas_n = 0; settle();
        chk("R10 col latched", c_col - b_col, 1);
        chk("R10 col_addr", col_addr, 10'h1C3);
        chk("R10 row from counter", row_addr, used);
        we_n = 0; settle();
        chk("R10 write enabled", c_din - b_din, 1);
        cas_n = 1; we_n = 1; ras_n = 1; settle();
        chk("R11 kind ctest", cycle_kind, 7);
        idle_pins();
    endtask

    task automatic t_page();
        int b_col = c_col, b_row = c_row;
        addr = 11'h444; ras_n = 0; settle();
        for (int k = 0; k < 3; k++) begin
            addr = 11'h010 + 11'(k); cas_n = 0; settle();
            cas_n = 1; settle();
        end
        chk("R3 page col count", c_col - b_col, 3);
        chk("R3 page last col", col_addr, 10'h012);
        chk("R3 page row_addr", row_addr, 11'h444);
        ras_n = 1; settle();
        chk("R3 page single row", c_row - b_row, 1);
        idle_pins();
    endtask

    task automatic t_wrap();
        while (exp_ctr != 11'h7FF) begin
            cas_n = 0; @(negedge clk); ras_n = 0; settle();
            ras_n = 1; cas_n = 1; settle();
            exp_ctr++;
        end
        t_cbr(1'b0);
        t_cbr(1'b0);
        chk("R8 counter wrapped", last_rr, 0);
    endtask

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
        finish_run();
    end

    initial begin
        t_reset();
        t_read(11'h5A3, 10'h2C7);
        t_early();
        t_delayed();
        t_we_cas_same();
        t_ras_only(11'h3D1);
        t_cbr(1'b0);
        t_cbr(1'b0);
        t_cbr(1'b1);
        t_hidden();
        t_ctest();
        t_page();
        t_wrap();
        finish_run();
    end
endmodule